// File: doc/BRIEF.md
# Register-File ALU with Flag Register

This block holds the sixteen 8-bit general registers of a small interpreter-style CPU and the arithmetic and logic unit that works on them. The last register (index 15) is also the flag register. A controller issues one operation at a time. It drives a start strobe together with a command class, a 4-bit operation selector, a destination/source index `x`, a second source index `y` and an 8-bit immediate. The block reads the operands, computes the result, writes it into register `x`, and then writes the flag register when the operation defines a flag. It pulses `done` once the last write has landed.

Register operations combine `Vx` and `Vy`. The immediate commands load a constant into `Vx` or add a constant to it. Selector or command codes that are not defined change nothing and pulse `illegal` instead of `done`. A synchronous read port lets the surrounding core (and the bench) read any register one cycle after presenting its index.

Top module: `vreg_alu`

## Requirements
- R1: After synchronous reset every register reads 0x00 and both `done` and `illegal` are low.
- R2: With command 0, selector 0 copies `Vy` into `Vx`. Selectors 1, 2 and 3 put `Vx|Vy`, `Vx&Vy` and `Vx^Vy` into `Vx`. None of these touches register 15 (when `x` is not 15).
- R3: With command 0 and selector 4, `Vx` receives the low 8 bits of `Vx+Vy`. Register 15 becomes 0x01 when the true sum is above 255 and 0x00 otherwise.
- R4: With command 0, selector 5 puts `Vx-Vy` (mod 256) into `Vx` and selector 7 puts `Vy-Vx`. Register 15 becomes 0x01 when the minuend is strictly greater than the subtrahend and 0x00 otherwise, so equal operands give 0x00.
- R5: With command 0, selector 6 shifts `Vx` right by one and selector 0xE shifts it left by one, filling with zero. Register 15 becomes the bit shifted out: bit 0 for the right shift, bit 7 for the left shift.
- R6: Command 1 loads the immediate into `Vx`. Command 2 puts `Vx+imm` modulo 256 into `Vx`. Neither changes register 15 unless `x` is 15.
- R7: When `x` is 15 and the operation defines a flag, the flag value is written after the result and is what register 15 holds afterwards.
- R8: Flag and result are computed from operand values read before any write of the same operation, including when `y` is 15.
- R9: Command 3, and command 0 with a selector other than 0–7 or 0xE, writes no register, pulses `illegal` for exactly one cycle and does not raise `done`. `illegal` is visible after the first clock edge following the accepting edge.
- R10: `done` is a one-cycle pulse. It is visible after the second clock edge following the edge that accepts `start` for operations without a flag, and after the third edge for operations that write the flag. `done` and `illegal` are never high together.
- R11: `start` is ignored while an operation is in progress.
- R12: `rd_data` shows the register selected by `rd_idx` one clock edge after the index is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an operation when idle |
| cmd | input | 2 | Command class: 0 register op, 1 load immediate, 2 add immediate, 3 reserved |
| sel | input | 4 | Operation selector for command 0 |
| x_idx | input | 4 | Destination and first operand register |
| y_idx | input | 4 | Second operand register |
| imm | input | 8 | Immediate constant |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 8 | Registered read data |
| done | output | 1 | Write-back complete pulse |
| illegal | output | 1 | Undefined operation pulse |

## Verification
A wrong operand latch or a wrong flag rule shows at the read port as a wrong destination value or a wrong register 15 value on the first read after `done`. A broken write sequence shows as register 15 holding the arithmetic result instead of the flag when `x` is 15. A sequencer fault shows within four cycles of `start`, as a `done` or `illegal` pulse at the wrong cycle or one that never comes. An illegal code that still writes shows as a changed register even though `illegal` pulsed.

// File: rtl/vreg_alu_pkg.sv
package vreg_alu_pkg;
  typedef enum logic [1:0] {
    CMD_REG  = 2'd0,
    CMD_LDI  = 2'd1,
    CMD_ADDI = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WRES = 2'd2,
    ST_WFLG = 2'd3
  } state_e;

  localparam logic [3:0] SEL_MOV  = 4'h0;
  localparam logic [3:0] SEL_OR   = 4'h1;
  localparam logic [3:0] SEL_AND  = 4'h2;
  localparam logic [3:0] SEL_XOR  = 4'h3;
  localparam logic [3:0] SEL_ADD  = 4'h4;
  localparam logic [3:0] SEL_SUB  = 4'h5;
  localparam logic [3:0] SEL_SHR  = 4'h6;
  localparam logic [3:0] SEL_RSUB = 4'h7;
  localparam logic [3:0] SEL_SHL  = 4'hE;
endpackage

// File: rtl/vreg_alu_regs.sv
module vreg_alu_regs #(
  parameter int NREG  = 16,
  parameter int W     = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     ra_data,
  output logic [W-1:0]     rb_data,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/vreg_alu_exec.sv
module vreg_alu_exec
  import vreg_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   cmd,
  input  logic [3:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res,
  output logic         flag,
  output logic         flag_en,
  output logic         bad
);
  logic [W:0] sum_ab;
  logic [W:0] sum_ai;

  assign sum_ab = {1'b0, a} + {1'b0, b};
  assign sum_ai = {1'b0, a} + {1'b0, imm};

  always_comb begin
    res     = a;
    flag    = 1'b0;
    flag_en = 1'b0;
    bad     = 1'b0;
    unique case (cmd_e'(cmd))
      CMD_LDI:  res = imm;
      CMD_ADDI: res = sum_ai[W-1:0];
      CMD_RSVD: bad = 1'b1;
      default: begin
        case (sel)
          SEL_MOV: res = b;
          SEL_OR:  res = a | b;
          SEL_AND: res = a & b;
          SEL_XOR: res = a ^ b;
          SEL_ADD: begin
            res = sum_ab[W-1:0]; flag = sum_ab[W]; flag_en = 1'b1;
          end
          SEL_SUB: begin
            res = a - b; flag = (a > b); flag_en = 1'b1;
          end
          SEL_RSUB: begin
            res = b - a; flag = (b > a); flag_en = 1'b1;
          end
          SEL_SHR: begin
            res = a >> 1; flag = a[0]; flag_en = 1'b1;
          end
          SEL_SHL: begin
            res = a << 1; flag = a[W-1]; flag_en = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/vreg_alu_ctrl.sv
module vreg_alu_ctrl
  import vreg_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = 4,
  parameter int FLAG_IDX = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [3:0]       sel,
  input  logic [IDX_W-1:0] x_idx,
  input  logic [IDX_W-1:0] y_idx,
  input  logic [W-1:0]     imm,
  output logic [1:0]       cmd_q,
  output logic [3:0]       sel_q,
  output logic [IDX_W-1:0] x_q,
  output logic [IDX_W-1:0] y_q,
  output logic [W-1:0]     imm_q,
  input  logic [W-1:0]     res,
  input  logic             flag,
  input  logic             flag_en,
  input  logic             bad,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [W-1:0]     wr_data,
  output logic             wr_is_flag,
  output logic             done,
  output logic             illegal
);
  localparam logic [IDX_W-1:0] FLAG_SEL = IDX_W'(FLAG_IDX);

  state_e       state;
  logic [W-1:0] res_q;
  logic         flag_q;
  logic         fen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
      cmd_q   <= '0;
      sel_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      imm_q   <= '0;
      res_q   <= '0;
      flag_q  <= 1'b0;
      fen_q   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          cmd_q <= cmd;
          sel_q <= sel;
          x_q   <= x_idx;
          y_q   <= y_idx;
          imm_q <= imm;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (bad) begin
            illegal <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            res_q  <= res;
            flag_q <= flag;
            fen_q  <= flag_en;
            state  <= ST_WRES;
          end
        end
        ST_WRES: begin
          if (fen_q) begin
            state <= ST_WFLG;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign wr_is_flag = (state == ST_WFLG);
  assign wr_en      = (state == ST_WRES) || wr_is_flag;
  assign wr_idx     = wr_is_flag ? FLAG_SEL : x_q;
  assign wr_data    = wr_is_flag ? {{(W-1){1'b0}}, flag_q} : res_q;
endmodule

// File: rtl/vreg_alu.sv
module vreg_alu #(
  parameter int NREG  = 16,
  parameter int W     = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [3:0]       sel,
  input  logic [IDX_W-1:0] x_idx,
  input  logic [IDX_W-1:0] y_idx,
  input  logic [W-1:0]     imm,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic             done,
  output logic             illegal
);
  localparam int FLAG_IDX = NREG - 1;

  logic [1:0]       cmd_q;
  logic [3:0]       sel_q;
  logic [IDX_W-1:0] x_q, y_q;
  logic [W-1:0]     imm_q;
  logic [W-1:0]     a_val, b_val, res;
  logic             flag, flag_en, bad;
  logic             wr_en, wr_is_flag;
  logic [IDX_W-1:0] wr_idx;
  logic [W-1:0]     wr_data;

  vreg_alu_ctrl #(.W(W), .IDX_W(IDX_W), .FLAG_IDX(FLAG_IDX)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .sel(sel),
    .x_idx(x_idx), .y_idx(y_idx), .imm(imm),
    .cmd_q(cmd_q), .sel_q(sel_q), .x_q(x_q), .y_q(y_q), .imm_q(imm_q),
    .res(res), .flag(flag), .flag_en(flag_en), .bad(bad),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_is_flag(wr_is_flag), .done(done), .illegal(illegal)
  );

  vreg_alu_regs #(.NREG(NREG), .W(W), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ra_idx(x_q), .rb_idx(y_q), .rd_idx(rd_idx),
    .ra_data(a_val), .rb_data(b_val), .rd_data(rd_data)
  );

  vreg_alu_exec #(.W(W)) exec_i (
    .cmd(cmd_q), .sel(sel_q), .a(a_val), .b(b_val), .imm(imm_q),
    .res(res), .flag(flag), .flag_en(flag_en), .bad(bad)
  );
endmodule

// File: rtl/vreg_alu_chk.sv
module vreg_alu_chk (
  input logic clk,
  input logic rst,
  input logic done,
  input logic illegal,
  input logic wr_en,
  input logic wr_is_flag
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal)); // R10
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_en)); // R10
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal); // R9
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !illegal); // R9
  AST_FLAG_LAST: assert property (@(posedge clk) disable iff (rst)
    wr_is_flag |=> done); // R7
endmodule

bind vreg_alu vreg_alu_chk chk_i (
  .clk(clk), .rst(rst), .done(done), .illegal(illegal),
  .wr_en(wr_en), .wr_is_flag(wr_is_flag)
);

// File: tb/vreg_alu_tb_top.sv
module vreg_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] cmd = '0;
  logic [3:0] sel = '0;
  logic [3:0] x_idx = '0;
  logic [3:0] y_idx = '0;
  logic [7:0] imm = '0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       done, illegal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vreg_alu dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .sel(sel),
    .x_idx(x_idx), .y_idx(y_idx), .imm(imm), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done), .illegal(illegal)
  );

  // {sel, a, b, expected Vx, expected V15}; V15 preset to 0xAA
  localparam logic [35:0] VEC [15] = '{
    36'h0_12_34_34_AA, 36'h1_F0_0F_FF_AA, 36'h2_3C_F0_30_AA,
    36'h3_FF_0F_F0_AA, 36'h4_C8_64_2C_01, 36'h4_10_20_30_00,
    36'h5_50_30_20_01, 36'h5_30_50_E0_00, 36'h5_40_40_00_00,
    36'h7_30_50_20_01, 36'h7_50_30_E0_00, 36'h6_81_00_40_01,
    36'h6_80_00_40_00, 36'hE_81_00_02_01, 36'hE_41_00_82_00
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [3:0] s,
                       input logic [3:0] x, input logic [3:0] y,
                       input logic [7:0] k, output int lat);
    @(negedge clk);
    start = 1'b1; cmd = c; sel = s; x_idx = x; y_idx = y; imm = k;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      lat++;
      if (done || illegal) break;
    end
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    @(negedge clk);
    rd_idx = i;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic string tag_of(input logic [3:0] s);
    if (s < 4) return "R2";
    if (s == 4) return "R3";
    if (s == 5 || s == 7) return "R4";
    return "R5";
  endfunction

  initial begin
    int lat;
    logic [7:0] v;
    logic [3:0] s;
    logic [7:0] a, b, er, ef;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 illegal", illegal, 0);
    rd(4'd0, v);  check("R1 V0", v, 8'h00);
    rd(4'd7, v);  check("R1 V7", v, 8'h00);
    rd(4'd15, v); check("R1 V15", v, 8'h00);

    // table of register operations, x=3, y=5
    for (int i = 0; i < 15; i++) begin
      {s, a, b, er, ef} = VEC[i];
      issue(2'd1, 4'd0, 4'd3, 4'd0, a, lat);
      issue(2'd1, 4'd0, 4'd5, 4'd0, b, lat);
      issue(2'd1, 4'd0, 4'd15, 4'd0, 8'hAA, lat);
      issue(2'd0, s, 4'd3, 4'd5, 8'h00, lat);
      check({tag_of(s), " R10 latency"}, lat, (ef == 8'hAA) ? 3 : 4);
      rd(4'd3, v);  check({tag_of(s), " Vx"}, v, er);
      rd(4'd15, v); check({tag_of(s), " flag"}, v, ef);
      rd(4'd5, v);  check({tag_of(s), " Vy kept"}, v, b);
    end

    // R6: immediate add wraps, flag untouched
    issue(2'd1, 4'd0, 4'd3, 4'd0, 8'hF0, lat);
    issue(2'd1, 4'd0, 4'd15, 4'd0, 8'hAA, lat);
    issue(2'd2, 4'd0, 4'd3, 4'd0, 8'h20, lat);
    check("R6 addi latency", lat, 3);
    rd(4'd3, v);  check("R6 addi wrap", v, 8'h10);
    rd(4'd15, v); check("R6 addi flag kept", v, 8'hAA);
    issue(2'd1, 4'd0, 4'd9, 4'd0, 8'h5A, lat);
    rd(4'd9, v);  check("R6 R12 load imm", v, 8'h5A);

    // R7: x = 15, flag overrides result
    issue(2'd1, 4'd0, 4'd15, 4'd0, 8'hC8, lat);
    issue(2'd1, 4'd0, 4'd4, 4'd0, 8'h64, lat);
    issue(2'd0, 4'h4, 4'd15, 4'd4, 8'h00, lat);
    rd(4'd15, v); check("R7 add into V15", v, 8'h01);
    issue(2'd1, 4'd0, 4'd15, 4'd0, 8'h10, lat);
    issue(2'd1, 4'd0, 4'd4, 4'd0, 8'h20, lat);
    issue(2'd0, 4'h5, 4'd15, 4'd4, 8'h00, lat);
    rd(4'd15, v); check("R7 sub into V15", v, 8'h00);

    // R8: y = 15 operand read before flag write
    issue(2'd1, 4'd0, 4'd3, 4'd0, 8'h01, lat);
    issue(2'd1, 4'd0, 4'd15, 4'd0, 8'hFF, lat);
    issue(2'd0, 4'h4, 4'd3, 4'd15, 8'h00, lat);
    rd(4'd3, v);  check("R8 sum with V15", v, 8'h00);
    rd(4'd15, v); check("R8 carry", v, 8'h01);

    // R9: illegal selector and reserved command
    issue(2'd1, 4'd0, 4'd3, 4'd0, 8'h77, lat);
    issue(2'd1, 4'd0, 4'd15, 4'd0, 8'hAA, lat);
    issue(2'd0, 4'h9, 4'd3, 4'd5, 8'h00, lat);
    check("R9 illegal latency", lat, 2);
    check("R9 illegal seen", illegal, 1);
    check("R9 no done", done, 0);
    rd(4'd3, v);  check("R9 Vx kept", v, 8'h77);
    rd(4'd15, v); check("R9 flag kept", v, 8'hAA);
    issue(2'd3, 4'h0, 4'd3, 4'd5, 8'h12, lat);
    check("R9 rsvd cmd latency", lat, 2);
    rd(4'd3, v);  check("R9 rsvd Vx kept", v, 8'h77);

    // R11: start held while busy is ignored
    @(negedge clk);
    start = 1'b1; cmd = 2'd1; x_idx = 4'd6; imm = 8'h11;
    @(posedge clk);
    #1 imm = 8'h22;
    @(posedge clk);
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    check("R11 R10 done", done, 1);
    lat = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check("R11 no second op", lat, 0);
    rd(4'd6, v); check("R11 V6", v, 8'h11);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule